// File: doc/BRIEF.md
# Rotating Framebuffer Scan Address Generator

This block produces the stream of byte addresses a display fetch engine uses to read a 16-bit-per-pixel framebuffer out to a portrait panel of 240 pixels by 320 lines. Each frame is 329 output lines, each line 240 pixels. The first 9 lines of a frame are blanking lines and the remaining 320 are visible. One address is offered per pixel on a valid/ready handshake. Two markers flag the first pixel of every line and the first pixel of every frame.

In portrait mode the buffer is read linearly from the base address. In landscape mode the same panel shows a 320-wide, 240-high image without copying it. Each output line walks down one column of the landscape buffer with a stride of one landscape row (640 bytes). Visible lines take the columns in reverse order. Every blanking line re-reads from the base address, so no padding memory is needed.

A one-cycle start pulse launches scanning. From then on the block runs frame after frame with no gap. The base address and the mode are taken at the start pulse and again at each frame boundary, so a change made mid-frame applies only to the next frame.

Top module: `scan_addr_gen`

## Requirements
- R1: While reset is held, and after it until a start pulse, `rd_valid`, `line_first` and `frame_first` are 0.
- R2: In the cycle after a start pulse from idle, `rd_valid` is 1, `rd_addr` equals the `base_addr` seen with the pulse, and both markers are 1.
- R3: In portrait mode (`landscape`=0), pixel p of line n sits at base + (n*240 + p)*2.
- R4: In landscape mode (`landscape`=1), consecutive pixels of one line differ by 640 bytes (320 pixels of 2 bytes).
- R5: In landscape mode, each of lines 0 to 8 (blanking) starts at the base address.
- R6: In landscape mode, visible line n (9 to 328) starts at base + (328 - n)*2.
- R7: After pixel 239 of line 328 is accepted, the next address is pixel 0 of line 0 of a new frame, with no idle cycle.
- R8: `line_first` is 1 exactly when pixel 0 of a line is offered. `frame_first` is 1 exactly when pixel 0 of line 0 is offered.
- R9: `base_addr` and `landscape` are sampled only at a start pulse from idle and with the acceptance of the last pixel of a frame. Changes at other times do not affect the frame in progress.
- R10: While `rd_valid` is 1 and `rd_ready` is 0, `rd_addr` and both markers hold their values.
- R11: Once started, `rd_valid` stays 1 until reset, and a further start pulse changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_addr | input | 32 | Byte address of the buffer's first line |
| landscape | input | 1 | 0 = linear portrait scan, 1 = rotated column scan |
| start | input | 1 | One-cycle pulse that starts scanning |
| rd_ready | input | 1 | Consumer accepts the current address |
| rd_valid | output | 1 | An address is offered |
| rd_addr | output | 32 | Byte address of the current pixel |
| line_first | output | 1 | Current address is pixel 0 of a line |
| frame_first | output | 1 | Current address is pixel 0 of line 0 |

## Verification
The bench goes after three corner cases. The first is the step from the last blanking line to the first visible line, where a wrong line index would start the rotated image one column off. The second is the frame wrap, where a generator that inserted a gap or failed to reload the base would skip or corrupt line 0. The third is a mode or base change made mid-frame, which a design sampling its inputs every line would apply to the rest of the frame. Ready is toggled on a pseudo-random pattern with long stalls so that a design advancing without a handshake shows moved addresses. A reduced-size instance is swept over several frames in both modes, and a default-size instance scans one full landscape frame plus the wrap.

// File: rtl/scan_pkg.sv
// Shared types for the scan address generator.
package scan_pkg;
    typedef enum logic {
        SCAN_PORTRAIT  = 1'b0,
        SCAN_LANDSCAPE = 1'b1
    } scan_mode_e;
endpackage

// File: rtl/scan_pos_counter.sv
// Pixel-within-line and line-within-frame position counters.
// Assumes: step only while a pixel is being accepted; clear restarts at 0/0.
module scan_pos_counter #(
    parameter int PIX_PER_LINE = 240,
    parameter int LINES        = 329,
    localparam int PIX_W       = $clog2(PIX_PER_LINE),
    localparam int LINE_W      = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [PIX_W-1:0]  pix_idx,
    output logic [LINE_W-1:0] line_idx,
    output logic              pix_last,
    output logic              line_last
);
    assign pix_last  = (pix_idx == PIX_W'(PIX_PER_LINE - 1));
    assign line_last = (line_idx == LINE_W'(LINES - 1));

    // Advance the pixel count and roll into the line count at line end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pix_idx  <= '0;
            line_idx <= '0;
        end else if (step) begin
            if (pix_last) begin
                pix_idx  <= '0;
                line_idx <= line_last ? '0 : line_idx + LINE_W'(1);
            end else begin
                pix_idx <= pix_idx + PIX_W'(1);
            end
        end
    end
endmodule

// File: rtl/scan_line_start.sv
// Start address of a line in rotated mode.
// Blanking lines read from the base; visible lines walk columns backwards.
module scan_line_start #(
    parameter int BLANK_LINES = 9,
    parameter int LINES       = 329,
    parameter int BYTES_PP    = 2,
    parameter int ADDR_W      = 32,
    localparam int LINE_W     = $clog2(LINES)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LINE_W-1:0] line,
    output logic [ADDR_W-1:0] start_addr
);
    logic [ADDR_W-1:0] rev_line;

    // Column offset counted back from the last line of the frame.
    always_comb begin
        rev_line = ADDR_W'(LINES - 1) - ADDR_W'(line);
        if (line < LINE_W'(BLANK_LINES))
            start_addr = base;
        else
            start_addr = base + rev_line * ADDR_W'(BYTES_PP);
    end
endmodule

// File: rtl/scan_addr_gen.sv
// Framebuffer scan address generator with linear and rotated modes.
// Offers one pixel address per handshake; inputs are sampled at frame starts.
// Assumes: start is a single-cycle pulse; reset is synchronous, active low.
module scan_addr_gen #(
    parameter int PIX_PER_LINE = 240,
    parameter int BLANK_LINES  = 9,
    parameter int VIS_LINES    = 320,
    parameter int BYTES_PP     = 2,
    parameter int ADDR_W       = 32,
    localparam int LINES       = BLANK_LINES + VIS_LINES,
    localparam int PIX_W       = $clog2(PIX_PER_LINE),
    localparam int LINE_W      = $clog2(LINES),
    localparam int COL_STRIDE  = VIS_LINES * BYTES_PP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              landscape,
    input  logic              start,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              line_first,
    output logic              frame_first
);
    import scan_pkg::*;

    logic              running;
    scan_mode_e        mode_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic [ADDR_W-1:0] rot_start;
    logic [PIX_W-1:0]  pix_idx;
    logic [LINE_W-1:0] line_idx;
    logic [LINE_W-1:0] line_nxt;
    logic              pix_last;
    logic              line_last;
    logic              fire;
    logic              start_go;

    assign fire     = running && rd_ready;
    assign start_go = start && !running;
    assign line_nxt = line_last ? '0 : line_idx + LINE_W'(1);

    scan_pos_counter #(
        .PIX_PER_LINE(PIX_PER_LINE),
        .LINES       (LINES)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_go),
        .step     (fire),
        .pix_idx  (pix_idx),
        .line_idx (line_idx),
        .pix_last (pix_last),
        .line_last(line_last)
    );

    scan_line_start #(
        .BLANK_LINES(BLANK_LINES),
        .LINES      (LINES),
        .BYTES_PP   (BYTES_PP),
        .ADDR_W     (ADDR_W)
    ) u_rot (
        .base      (base_q),
        .line      (line_nxt),
        .start_addr(rot_start)
    );

    // Next address: frame reload, line start, or in-line stride.
    always_comb begin
        if (pix_last && line_last)
            addr_nxt = base_addr;
        else if (pix_last)
            addr_nxt = (mode_q == SCAN_LANDSCAPE) ? rot_start
                                                  : addr_q + ADDR_W'(BYTES_PP);
        else
            addr_nxt = (mode_q == SCAN_LANDSCAPE) ? addr_q + ADDR_W'(COL_STRIDE)
                                                  : addr_q + ADDR_W'(BYTES_PP);
    end

    // Run state, frame-sampled configuration and the address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            mode_q  <= SCAN_PORTRAIT;
            base_q  <= '0;
            addr_q  <= '0;
        end else if (start_go) begin
            running <= 1'b1;
            mode_q  <= scan_mode_e'(landscape);
            base_q  <= base_addr;
            addr_q  <= base_addr;
        end else if (fire) begin
            addr_q <= addr_nxt;
            if (pix_last && line_last) begin
                mode_q <= scan_mode_e'(landscape);
                base_q <= base_addr;
            end
        end
    end

    assign rd_valid    = running;
    assign rd_addr     = addr_q;
    assign line_first  = running && (pix_idx == '0);
    assign frame_first = running && (pix_idx == '0) && (line_idx == '0);
endmodule

// File: rtl/scan_addr_gen_chk.sv
// Property checker for the scan address generator, bound to its top.
module scan_addr_gen_chk #(
    parameter int PIX_PER_LINE = 240,
    parameter int BLANK_LINES  = 9,
    parameter int VIS_LINES    = 320,
    parameter int BYTES_PP     = 2,
    parameter int ADDR_W       = 32,
    localparam int LINES       = BLANK_LINES + VIS_LINES,
    localparam int LINE_W      = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] base_addr,
    input logic              rd_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              line_first,
    input logic              frame_first,
    input logic              mode_bit,
    input logic [ADDR_W-1:0] base_q,
    input logic [LINE_W-1:0] line_idx,
    input logic              pix_last,
    input logic              line_last
);
    logic fire;
    assign fire = rd_valid && rd_ready;

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !line_first && !frame_first));

    a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !rd_valid) |=> (rd_valid && frame_first && rd_addr == $past(base_addr)));

    a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !mode_bit && !(pix_last && line_last))
        |=> rd_addr == $past(rd_addr) + ADDR_W'(BYTES_PP));

    a_r4_column_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_bit && !pix_last)
        |=> rd_addr == $past(rd_addr) + ADDR_W'(VIS_LINES * BYTES_PP));

    a_r5_blank_from_base: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_bit && pix_last && (line_idx < LINE_W'(BLANK_LINES - 1)))
        |=> rd_addr == base_q);

    a_r6_first_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_bit && pix_last && (line_idx == LINE_W'(BLANK_LINES - 1)))
        |=> rd_addr == base_q + ADDR_W'((VIS_LINES - 1) * BYTES_PP));

    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && pix_last && line_last)
        |=> (rd_valid && frame_first && rd_addr == $past(base_addr)));

    a_r8_frame_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_first |-> line_first);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready)
        |=> (rd_valid && $stable(rd_addr) && $stable(line_first) && $stable(frame_first)));

    a_r11_stay_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_valid);
endmodule

bind scan_addr_gen scan_addr_gen_chk #(
    .PIX_PER_LINE(PIX_PER_LINE),
    .BLANK_LINES (BLANK_LINES),
    .VIS_LINES   (VIS_LINES),
    .BYTES_PP    (BYTES_PP),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .base_addr  (base_addr),
    .rd_ready   (rd_ready),
    .rd_valid   (rd_valid),
    .rd_addr    (rd_addr),
    .line_first (line_first),
    .frame_first(frame_first),
    .mode_bit   (mode_q),
    .base_q     (base_q),
    .line_idx   (line_idx),
    .pix_last   (pix_last),
    .line_last  (line_last)
);

// File: tb/scan_addr_gen_tb_top.sv
`timescale 1ns/1ps
// Bench: a reduced instance swept over many frames in both modes, and a
// default instance scanned through one full rotated frame plus the wrap.
module scan_addr_gen_tb_top;
    localparam int N = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        start [N];
    logic        land  [N];
    logic [31:0] base  [N];
    logic        ready [N];
    logic        valid [N];
    logic        lf    [N];
    logic        ff    [N];
    logic [31:0] addr  [N];

    scan_addr_gen #(.PIX_PER_LINE(6), .BLANK_LINES(3), .VIS_LINES(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .base_addr(base[0]), .landscape(land[0]),
        .start(start[0]), .rd_ready(ready[0]), .rd_valid(valid[0]),
        .rd_addr(addr[0]), .line_first(lf[0]), .frame_first(ff[0]));

    scan_addr_gen dut_full_i (
        .clk(clk), .rst_n(rst_n), .base_addr(base[1]), .landscape(land[1]),
        .start(start[1]), .rd_ready(ready[1]), .rd_valid(valid[1]),
        .rd_addr(addr[1]), .line_first(lf[1]), .frame_first(ff[1]));

    function automatic int n_pix(int k);   return (k == 0) ? 6 : 240;  endfunction
    function automatic int n_blank(int k); return (k == 0) ? 3 : 9;    endfunction
    function automatic int n_vis(int k);   return (k == 0) ? 5 : 320;  endfunction
    function automatic int n_tot(int k);   return n_blank(k) + n_vis(k); endfunction

    bit          m_run [N];
    bit          m_mode[N];
    logic [31:0] m_base[N];
    int          m_line[N];
    int          m_pix [N];
    int          m_frm [N];
    bit          pend_start[N];
    bit          pend_latch[N];
    bit          stall [N];
    logic [31:0] p_addr[N];
    logic        p_lf  [N];
    logic        p_ff  [N];

    int checks = 0;
    int errors = 0;
    logic [7:0] lfsr = 8'h5A;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(int k, bit mode, logic [31:0] b, int ln, int px);
        logic [31:0] st;
        if (!mode) return b + 32'((ln * n_pix(k) + px) * 2);
        st = (ln < n_blank(k)) ? b : b + 32'((n_tot(k) - 1 - ln) * 2);
        return st + 32'(px * n_vis(k) * 2);
    endfunction

    function automatic string tag_of(int k);
        if (m_line[k] == 0 && m_pix[k] == 0) return (m_frm[k] == 0) ? "R2" : "R7/R9";
        if (!m_mode[k]) return "R3";
        if (m_pix[k] > 0) return "R4";
        if (m_line[k] < n_blank(k)) return "R5";
        return "R6";
    endfunction

    // Compare one instance against the model, then advance the model.
    task automatic sample_one(int k);
        if (pend_start[k] && !m_run[k]) begin
            m_run[k] = 1; m_mode[k] = land[k]; m_base[k] = base[k];
            m_line[k] = 0; m_pix[k] = 0; m_frm[k] = 0;
        end
        pend_start[k] = 0;
        if (pend_latch[k]) begin
            m_mode[k] = land[k]; m_base[k] = base[k]; pend_latch[k] = 0;
        end
        chk(m_run[k] ? "R11" : "R1", 32'(valid[k]), 32'(m_run[k]));
        if (stall[k]) begin
            chk("R10", addr[k], p_addr[k]);
            chk("R10", 32'(lf[k]), 32'(p_lf[k]));
            chk("R10", 32'(ff[k]), 32'(p_ff[k]));
        end
        if (m_run[k] && ready[k]) begin
            chk(tag_of(k), addr[k], exp_addr(k, m_mode[k], m_base[k], m_line[k], m_pix[k]));
            chk("R8", 32'(lf[k]), 32'(m_pix[k] == 0));
            chk("R8", 32'(ff[k]), 32'(m_pix[k] == 0 && m_line[k] == 0));
            if (m_pix[k] == n_pix(k) - 1) begin
                m_pix[k] = 0;
                if (m_line[k] == n_tot(k) - 1) begin
                    m_line[k] = 0; m_frm[k]++; pend_latch[k] = 1;
                end else begin
                    m_line[k]++;
                end
            end else begin
                m_pix[k]++;
            end
        end
        stall[k]  = m_run[k] && !ready[k];
        p_addr[k] = addr[k];
        p_lf[k]   = lf[k];
        p_ff[k]   = ff[k];
    endtask

    task automatic tick(input bit r0, input bit r1);
        @(negedge clk);
        ready[0] = r0;
        ready[1] = r1;
        #1;
        if (rst_n) begin
            sample_one(0);
            sample_one(1);
        end
    endtask

    task automatic raise_start(int k, bit mode, logic [31:0] b);
        land[k] = mode; base[k] = b; start[k] = 1'b1; pend_start[k] = 1;
    endtask

    function automatic logic [7:0] lfsr_next(logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    initial begin
        #3_900_000;
        errors++;
        checks++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) begin
            start[k] = 0; land[k] = 0; base[k] = '0; ready[k] = 0;
            m_run[k] = 0; m_mode[k] = 0; m_base[k] = '0; m_line[k] = 0; m_pix[k] = 0;
            m_frm[k] = 0; pend_start[k] = 0; pend_latch[k] = 0; stall[k] = 0;
            p_addr[k] = '0; p_lf[k] = 0; p_ff[k] = 0;
        end
        repeat (3) tick(0, 0);
        for (int k = 0; k < N; k++) begin
            chk("R1", 32'(valid[k]), 32'd0);
            chk("R1", 32'(lf[k]), 32'd0);
            chk("R1", 32'(ff[k]), 32'd0);
        end
        rst_n = 1'b1;
        repeat (2) tick(1, 1);

        // R2: start portrait on the reduced instance.
        raise_start(0, 1'b0, 32'h0000_1000);
        tick(1, 0);
        start[0] = 0;

        for (int i = 0; i < 420; i++) begin
            lfsr = lfsr_next(lfsr);
            if (i == 30) raise_start(0, 1'b0, 32'h0000_2222);    // R11: ignored pulse
            if (i == 31) start[0] = 0;
            if (i == 80)  begin land[0] = 1'b1; base[0] = 32'h0000_8000; end // R9
            if (i == 250) begin land[0] = 1'b0; base[0] = 32'h0000_0040; end // R9
            if (i >= 300 && i < 330) tick(0, 0);                 // R10: long stall
            else tick(lfsr[0] | lfsr[1], 0);
        end
        land[0] = 1'b1;
        base[0] = 32'h0000_A000;
        for (int i = 0; i < 200; i++) begin
            lfsr = lfsr_next(lfsr);
            tick(lfsr[0] | lfsr[2], 0);
        end

        // Default-size instance: one full rotated frame plus the wrap.
        raise_start(1, 1'b1, 32'h2000_0000);
        tick(0, 1);
        start[1] = 0;
        for (int i = 0; i < 240 * 329 + 250; i++) begin
            tick(0, (i % 997) != 5);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule